// File: doc/BRIEF.md
# Sequential Floating-Point Divider with Exact Residue

This block divides one sign-magnitude floating-point operand by another. Each operand has a sign bit, a biased exponent of `EXP_W` bits (bias is 2^(EXP_W-1)) and an unsigned fraction of `FRAC_W` bits read as a value in [0, 1). A fraction is normalized when its top bit (bit `FRAC_W-1`) is 1. Operand A normally plays the dividend and operand B the divisor. A reverse-mode input exchanges those two roles. The result is a normalized quotient and an exact signed residue, so a caller can chain words for extended precision.

A division starts when `start_i` is sampled high while the block is idle. The dividend fraction is normalized first. It is then shifted left by one more place if it is smaller than the divisor fraction. A restoring loop then produces one quotient bit per clock, `FRAC_W` bits in all. With rounding enabled, the divisor fraction is added below the dividend before the loop and removed from the remainder after it. This gives a round-half-up quotient and keeps the residue exact.

An unnormalized divisor does not divide. It raises `trap_o` together with `done_o` and leaves the previous results in place.

Top module: `fdiv_core`

## Requirements
- R1: While reset is applied and until the first result, `done_o`, `trap_o`, `busy_o` and all result outputs read 0.
- R2: If the divisor fraction has bit `FRAC_W-1` clear, `trap_o` and `done_o` pulse together one cycle after the start edge. The quotient and residue outputs keep their previous values.
- R3: With `rev_i`=1, operand B is the dividend and operand A is the divisor. With `rev_i`=0, A is the dividend and B the divisor.
- R4: Let the dividend fraction be d, with n leading zeros, and let dn = d<<n. Let s=1 if dn is less than the divisor fraction v, else s=0. Then the quotient exponent is (dividend exp - n - divisor exp + 2^(EXP_W-1) + 1 - s) mod 2^EXP_W. Every nonzero quotient fraction has bit `FRAC_W-1` set.
- R5: With `rnd_i`=0, the quotient fraction is floor(D*2^(FRAC_W-1)/v), where D = dn<<s.
- R6: With `rnd_i`=1, the quotient fraction is floor((D*2^FRAC_W + v)/(2v)), which is round half up.
- R7: The residue is res = D*2^(FRAC_W-1) - q*v. `rem_mag_o` carries |res|. `rem_sign_o` is the dividend sign XOR (res<0), and is 0 when |res| is 0.
- R8: The quotient sign is the XOR of the dividend and divisor signs.
- R9: A zero dividend fraction with a normalized divisor gives an all-zero quotient and residue, one cycle after the start edge.
- R10: A normal division raises `done_o` for exactly one cycle, `FRAC_W`+1 cycles after the start edge. `busy_o` is high from the start edge until then and low while `done_o` is high.
- R11: A start pulse or operand change while `busy_o` is high has no effect on the result in progress or on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division when idle |
| rnd_i | input | 1 | 1 = rounded quotient, 0 = truncated |
| rev_i | input | 1 | 1 = B divided by A |
| a_sign_i | input | 1 | Operand A sign |
| a_exp_i | input | EXP_W | Operand A biased exponent |
| a_frac_i | input | FRAC_W | Operand A fraction |
| b_sign_i | input | 1 | Operand B sign |
| b_exp_i | input | EXP_W | Operand B biased exponent |
| b_frac_i | input | FRAC_W | Operand B fraction |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion strobe |
| trap_o | output | 1 | Divisor was unnormalized (with done_o) |
| q_sign_o | output | 1 | Quotient sign |
| q_exp_o | output | EXP_W | Quotient biased exponent |
| q_frac_o | output | FRAC_W | Quotient fraction |
| rem_sign_o | output | 1 | Residue sign |
| rem_mag_o | output | FRAC_W | Residue magnitude |

## Verification
The partial remainder, the shifted low bits and the quotient accumulator are hidden. A fault in any one of them shows up at the single `done_o` strobe as a wrong quotient fraction, residue or both. The residue identity of R7 lets such a fault be caught even when the quotient happens to match. A fault in the step counter or the state register shows up as a strobe that comes early or late against the fixed latency, or as `busy_o` and `done_o` both high. A fault in the alignment path shows up as a wrong exponent or an unnormalized quotient in the same result.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fdiv_state_e;
endpackage

// File: rtl/fdiv_rst_sync.sv
module fdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fdiv_lzc.sv
module fdiv_lzc #(
  parameter int W = 35
) (
  input  logic [W-1:0]           vec_i,
  output logic [$clog2(W+1)-1:0] lz_o,
  output logic                   zero_o
);
  localparam int CW = $clog2(W+1);

  // Highest set bit wins: scanning upward, the last hit overwrites.
  always_comb begin
    lz_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) lz_o = CW'(W - 1 - i);
    end
  end

  assign zero_o = ~|vec_i;
endmodule

// File: rtl/fdiv_prep.sv
module fdiv_prep #(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 16
) (
  input  logic              rev_i,
  input  logic              rnd_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  output logic              trap_o,
  output logic              zero_o,
  output logic              d_sign_o,
  output logic              q_sign_o,
  output logic [EXP_W-1:0]  q_exp_o,
  output logic [FRAC_W:0]   p_init_o,
  output logic [FRAC_W-1:0] low_o,
  output logic [FRAC_W:0]   y_o
);
  localparam int CW = $clog2(FRAC_W+1);
  localparam logic [EXP_W-1:0] BIAS = {1'b1, {(EXP_W-1){1'b0}}};

  logic              dvd_sign, dvs_sign;
  logic [EXP_W-1:0]  dvd_exp, dvs_exp;
  logic [FRAC_W-1:0] dvd_frac, dvs_frac, dvd_norm;
  logic [CW-1:0]     lead;
  logic              dvd_zero, below;

  // role exchange for reverse division (R3)
  always_comb begin
    if (rev_i) begin
      dvd_sign = b_sign_i; dvd_exp = b_exp_i; dvd_frac = b_frac_i;
      dvs_sign = a_sign_i; dvs_exp = a_exp_i; dvs_frac = a_frac_i;
    end else begin
      dvd_sign = a_sign_i; dvd_exp = a_exp_i; dvd_frac = a_frac_i;
      dvs_sign = b_sign_i; dvs_exp = b_exp_i; dvs_frac = b_frac_i;
    end
  end

  fdiv_lzc #(.W(FRAC_W)) u_lzc (
    .vec_i  (dvd_frac),
    .lz_o   (lead),
    .zero_o (dvd_zero)
  );

  always_comb begin
    dvd_norm = dvd_frac << lead;
    below    = dvd_norm < dvs_frac;
    p_init_o = below ? {dvd_norm, 1'b0} : {1'b0, dvd_norm};
    low_o    = rnd_i ? dvs_frac : '0;
    y_o      = {dvs_frac, 1'b0};
    trap_o   = ~dvs_frac[FRAC_W-1];
    zero_o   = dvd_zero;
    d_sign_o = dvd_sign;
    q_sign_o = dvd_sign ^ dvs_sign;
    q_exp_o  = dvd_exp - EXP_W'(lead) - dvs_exp + BIAS + EXP_W'(!below);
  end
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
  parameter int FRAC_W = 35
) (
  input  logic [FRAC_W:0] p_i,
  input  logic            bit_i,
  input  logic [FRAC_W:0] y_i,
  output logic [FRAC_W:0] p_o,
  output logic            q_o
);
  logic [FRAC_W+1:0] trial, diff;

  always_comb begin
    trial = {p_i, bit_i};
    diff  = trial - {1'b0, y_i};
    q_o   = ~diff[FRAC_W+1];
    p_o   = q_o ? diff[FRAC_W:0] : trial[FRAC_W:0];
  end
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core #(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rnd_i,
  input  logic              rev_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [FRAC_W-1:0] a_frac_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [FRAC_W-1:0] b_frac_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o,
  output logic              q_sign_o,
  output logic [EXP_W-1:0]  q_exp_o,
  output logic [FRAC_W-1:0] q_frac_o,
  output logic              rem_sign_o,
  output logic [FRAC_W-1:0] rem_mag_o
);
  import fdiv_pkg::*;

  localparam int CW = $clog2(FRAC_W+1);
  localparam logic [CW-1:0] LAST = CW'(FRAC_W - 1);

  logic rst_core_n;

  fdiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // prep outputs
  logic              pr_trap, pr_zero, pr_dsgn, pr_qsgn;
  logic [EXP_W-1:0]  pr_exp;
  logic [FRAC_W:0]   pr_p, pr_y;
  logic [FRAC_W-1:0] pr_low;

  fdiv_prep #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_prep (
    .rev_i    (rev_i),
    .rnd_i    (rnd_i),
    .a_sign_i (a_sign_i),
    .a_exp_i  (a_exp_i),
    .a_frac_i (a_frac_i),
    .b_sign_i (b_sign_i),
    .b_exp_i  (b_exp_i),
    .b_frac_i (b_frac_i),
    .trap_o   (pr_trap),
    .zero_o   (pr_zero),
    .d_sign_o (pr_dsgn),
    .q_sign_o (pr_qsgn),
    .q_exp_o  (pr_exp),
    .p_init_o (pr_p),
    .low_o    (pr_low),
    .y_o      (pr_y)
  );

  // working state
  fdiv_state_e       state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [FRAC_W:0]   part_q, part_d, ydiv_q;
  logic [FRAC_W-1:0] low_q, low_d, quo_q, quo_d;
  logic [EXP_W-1:0]  qexp_q;
  logic              qsgn_q, dsgn_q, rnd_q, trapf_q, zerof_q;

  // step datapath
  logic [FRAC_W:0] st_p;
  logic            st_q;

  fdiv_step #(.FRAC_W(FRAC_W)) u_step (
    .p_i   (part_q),
    .bit_i (low_q[FRAC_W-1]),
    .y_i   (ydiv_q),
    .p_o   (st_p),
    .q_o   (st_q)
  );

  // enables
  logic load_en, step_en, fin_en;

  always_comb begin
    load_en = (state_q == ST_IDLE) && start_i;
    step_en = (state_q == ST_RUN);
    fin_en  = (state_q == ST_FIN);
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    part_d  = part_q;
    low_d   = low_q;
    quo_d   = quo_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = (pr_trap || pr_zero) ? ST_FIN : ST_RUN;
        cnt_d   = '0;
        part_d  = pr_p;
        low_d   = pr_low;
        quo_d   = '0;
      end
      ST_RUN: begin
        part_d = st_p;
        low_d  = {low_q[FRAC_W-2:0], 1'b0};
        quo_d  = {quo_q[FRAC_W-2:0], st_q};
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // residue: remove the rounding addend, then halve
  logic [FRAC_W+1:0] res_raw, res_abs, rnd_sub;
  logic              res_neg;
  logic [FRAC_W-1:0] res_mag;

  always_comb begin
    rnd_sub = rnd_q ? {2'b00, ydiv_q[FRAC_W:1]} : '0;
    res_raw = {1'b0, part_q} - rnd_sub;
    res_neg = res_raw[FRAC_W+1];
    res_abs = res_neg ? (~res_raw + 1'b1) : res_raw;
    res_mag = res_abs[FRAC_W:1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      part_q  <= '0;
      low_q   <= '0;
      quo_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en || step_en) begin
        cnt_q  <= cnt_d;
        part_q <= part_d;
        low_q  <= low_d;
        quo_q  <= quo_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ydiv_q  <= '0;
      qexp_q  <= '0;
      qsgn_q  <= 1'b0;
      dsgn_q  <= 1'b0;
      rnd_q   <= 1'b0;
      trapf_q <= 1'b0;
      zerof_q <= 1'b0;
    end else if (load_en) begin
      ydiv_q  <= pr_y;
      qexp_q  <= pr_exp;
      qsgn_q  <= pr_qsgn;
      dsgn_q  <= pr_dsgn;
      rnd_q   <= rnd_i;
      trapf_q <= pr_trap;
      zerof_q <= pr_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_o     <= 1'b0;
      trap_o     <= 1'b0;
      q_sign_o   <= 1'b0;
      q_exp_o    <= '0;
      q_frac_o   <= '0;
      rem_sign_o <= 1'b0;
      rem_mag_o  <= '0;
    end else begin
      done_o <= fin_en;
      trap_o <= fin_en && trapf_q;
      if (fin_en && !trapf_q) begin
        if (zerof_q) begin
          q_sign_o   <= 1'b0;
          q_exp_o    <= '0;
          q_frac_o   <= '0;
          rem_sign_o <= 1'b0;
          rem_mag_o  <= '0;
        end else begin
          q_sign_o   <= qsgn_q;
          q_exp_o    <= qexp_q;
          q_frac_o   <= quo_q;
          rem_sign_o <= (res_mag != '0) && (dsgn_q ^ res_neg);
          rem_mag_o  <= res_mag;
        end
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              trap_o,
  input logic [EXP_W-1:0]  q_exp_o,
  input logic [FRAC_W-1:0] q_frac_o,
  input logic              rem_sign_o,
  input logic [FRAC_W-1:0] rem_mag_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R10
  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> done_o); // R2
  AST_TRAP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && trap_o) |-> ($stable(q_frac_o) && $stable(q_exp_o))); // R2
  AST_QUOT_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (q_frac_o != '0)) |-> q_frac_o[FRAC_W-1]); // R4
  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(q_frac_o) && $stable(rem_mag_o))); // R11
  AST_ZERO_REM_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_mag_o == '0) |-> !rem_sign_o); // R7
endmodule

bind fdiv_core fdiv_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_fdiv_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .trap_o     (trap_o),
  .q_exp_o    (q_exp_o),
  .q_frac_o   (q_frac_o),
  .rem_sign_o (rem_sign_o),
  .rem_mag_o  (rem_mag_o)
);

// File: tb/fdiv_core_bench.sv
module fdiv_core_bench;
  localparam int FW = 35;
  localparam int EW = 16;
  localparam int NV = 10;

  // {rev, rnd, a_s, a_e, a_f, b_s, b_e, b_f}
  localparam logic [105:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h8000, 35'h6_0000_0000, 1'b0, 16'h8000, 35'h4_0000_0000},
    {1'b0, 1'b1, 1'b0, 16'h8003, 35'h5_5555_5555, 1'b1, 16'h7FFF, 35'h6_0000_0003},
    {1'b0, 1'b0, 1'b0, 16'h8003, 35'h5_5555_5555, 1'b1, 16'h7FFF, 35'h6_0000_0003},
    {1'b0, 1'b1, 1'b1, 16'h8010, 35'h0_0000_1234, 1'b0, 16'h8000, 35'h7_0000_0001},
    {1'b1, 1'b1, 1'b1, 16'h7FF0, 35'h4_0000_0001, 1'b1, 16'h8020, 35'h7_FFFF_FFFF},
    {1'b0, 1'b1, 1'b0, 16'h8000, 35'h7_FFFF_FFFF, 1'b0, 16'h8000, 35'h4_0000_0000},
    {1'b0, 1'b1, 1'b1, 16'h8100, 35'h5_A5A5_A5A5, 1'b0, 16'h8100, 35'h5_A5A5_A5A5},
    {1'b0, 1'b1, 1'b0, 16'h8000, 35'h4_0000_0000, 1'b1, 16'h8000, 35'h7_FFFF_FFFF},
    {1'b0, 1'b0, 1'b0, 16'h0001, 35'h4_C0DE_1357, 1'b0, 16'hFFFE, 35'h5_1111_2222},
    {1'b1, 1'b0, 1'b0, 16'h8000, 35'h4_0000_0001, 1'b1, 16'h8000, 35'h0_0000_0001}
  };

  logic          clk, rst_n, start, rnd, rev;
  logic          a_s, b_s;
  logic [EW-1:0] a_e, b_e;
  logic [FW-1:0] a_f, b_f;
  logic          busy, done, trap, q_s, r_s;
  logic [EW-1:0] q_e;
  logic [FW-1:0] q_f, r_m;

  int checks = 0;
  int fails  = 0;

  fdiv_core #(.FRAC_W(FW), .EXP_W(EW)) u_fdiv_core (
    .clk (clk), .rst_n (rst_n), .start_i (start), .rnd_i (rnd), .rev_i (rev),
    .a_sign_i (a_s), .a_exp_i (a_e), .a_frac_i (a_f),
    .b_sign_i (b_s), .b_exp_i (b_e), .b_frac_i (b_f),
    .busy_o (busy), .done_o (done), .trap_o (trap),
    .q_sign_o (q_s), .q_exp_o (q_e), .q_frac_o (q_f),
    .rem_sign_o (r_s), .rem_mag_o (r_m)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model from the requirements
  task automatic model(input logic rv, input logic rd,
                       input logic as, input logic [EW-1:0] ae, input logic [FW-1:0] af,
                       input logic bs, input logic [EW-1:0] be, input logic [FW-1:0] bf,
                       output logic xtrap, output logic xzero, output logic xqs,
                       output logic [EW-1:0] xqe, output logic [FW-1:0] xqf,
                       output logic xrs, output logic [FW-1:0] xrm);
    logic ds, vs, sm, neg;
    logic [EW-1:0] de, ve;
    logic [FW-1:0] df, vf, dn;
    logic [127:0] dd, xx, yy, qq, rr, rs, mg, ad;
    int nz;
    ds = rv ? bs : as; de = rv ? be : ae; df = rv ? bf : af;
    vs = rv ? as : bs; ve = rv ? ae : be; vf = rv ? af : bf;
    xtrap = !vf[FW-1];
    xzero = (df == '0);
    dn = df; nz = 0;
    while (!dn[FW-1] && nz < FW) begin dn = dn << 1; nz++; end
    sm = dn < vf;
    dd = sm ? {dn, 1'b0} : {1'b0, dn};
    ad = rd ? 128'(vf) : 128'd0;
    xx = (dd << FW) + ad;
    yy = {vf, 1'b0};
    qq = (yy != 0) ? xx / yy : 128'd0;
    rr = xx - qq * yy;
    rs = rr - ad;
    neg = rs[127];
    mg = neg ? -rs : rs;
    mg = mg >> 1;
    xqf = qq[FW-1:0];
    xqe = de - EW'(nz) - ve + 16'h8000 + (sm ? 16'd0 : 16'd1);
    xqs = ds ^ vs;
    xrm = mg[FW-1:0];
    xrs = (mg != 0) && (ds ^ neg);
  endtask

  task automatic run_op(input logic rv, input logic rd,
                        input logic as, input logic [EW-1:0] ae, input logic [FW-1:0] af,
                        input logic bs, input logic [EW-1:0] be, input logic [FW-1:0] bf,
                        input logic disturb, output int lat);
    @(negedge clk);
    rev = rv; rnd = rd; a_s = as; a_e = ae; a_f = af; b_s = bs; b_e = be; b_f = bf;
    start = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      if (disturb && lat == 5) begin
        start = 1'b1; a_f = ~af; b_f = 35'h4_0000_0003; rnd = ~rd; rev = ~rv;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic full_check(input string tag, input logic [105:0] v, input logic disturb);
    logic xt, xz, xqs, xrs;
    logic [EW-1:0] xqe;
    logic [FW-1:0] xqf, xrm;
    int lat;
    model(v[105], v[104], v[103], v[102:87], v[86:52], v[51], v[50:35], v[34:0],
          xt, xz, xqs, xqe, xqf, xrs, xrm);
    run_op(v[105], v[104], v[103], v[102:87], v[86:52], v[51], v[50:35], v[34:0], disturb, lat);
    check({tag, " R5/R6 quotient fraction"}, 64'(q_f), 64'(xqf));
    check({tag, " R4 quotient exponent"}, 64'(q_e), 64'(xqe));
    check({tag, " R8 quotient sign"}, 64'(q_s), 64'(xqs));
    check({tag, " R7 residue"}, 64'({r_s, r_m}), 64'({xrs, xrm}));
    check({tag, " R10 latency"}, 64'(lat), 64'(FW + 1));
    check({tag, " R2 no trap"}, 64'(trap), 64'(xt));
    @(negedge clk);
    check({tag, " R10 done single cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [FW-1:0] keep_q;
    logic [EW-1:0] keep_e;
    int lat;
    rst_n = 1'b0; start = 1'b0; rnd = 1'b0; rev = 1'b0;
    a_s = 1'b0; a_e = '0; a_f = '0; b_s = 1'b0; b_e = '0; b_f = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs in reset", 64'({done, trap, busy, q_s, r_s}), 64'd0);
    check("R1 result in reset", 64'(q_f | r_m | FW'(q_e)), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 64'({done, busy}), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) full_check($sformatf("vec%0d", i), VEC[i], 1'b0);

    // R11 disturbance while busy
    full_check("R11 busy-ignore", VEC[1], 1'b1);
    full_check("R11 busy-ignore rev", VEC[4], 1'b1);

    // R2 trap keeps previous result
    keep_q = q_f; keep_e = q_e;
    run_op(1'b0, 1'b1, 1'b0, 16'h8000, 35'h4_0000_0000, 1'b0, 16'h8000, 35'h3_FFFF_FFFF, 1'b0, lat);
    check("R2 trap flag", 64'(trap), 64'd1);
    check("R2 trap latency", 64'(lat), 64'd1);
    check("R2 quotient held", 64'({q_e, q_f}), 64'({keep_e, keep_q}));
    @(negedge clk);
    check("R2 trap single cycle", 64'({trap, done}), 64'd0);

    // R3 reverse: A unnormalized becomes divisor -> trap
    run_op(1'b1, 1'b0, 1'b0, 16'h8000, 35'h1_0000_0000, 1'b0, 16'h8000, 35'h5_0000_0000, 1'b0, lat);
    check("R3 reverse trap", 64'(trap), 64'd1);
    // same operands without reverse: no trap, normalizes dividend
    full_check("R3 forward", {1'b0, 1'b0, 1'b0, 16'h8000, 35'h1_0000_0000, 1'b0, 16'h8000, 35'h5_0000_0000}, 1'b0);

    // R9 zero dividend
    run_op(1'b0, 1'b1, 1'b1, 16'h8123, 35'h0, 1'b0, 16'h8000, 35'h6_0000_0000, 1'b0, lat);
    check("R9 zero latency", 64'(lat), 64'd1);
    check("R9 zero quotient", 64'({q_s, q_e, q_f}), 64'd0);
    check("R9 zero residue", 64'({r_s, r_m}), 64'd0);
    check("R9 zero no trap", 64'(trap), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule